// File: doc/BRIEF.md
# Serial DAC Front-End Controller

This block is the digital input side of a 12-bit voltage-output converter. A host sends 16-bit words over a three-wire serial link: a serial clock, an active-low frame select and a data line. Inside the core clock domain, the block oversamples the three pins and moves the bits into a shift register, most significant bit first. A data bit is taken on each falling serial-clock edge while the frame select is low. When the frame select rises after exactly sixteen bits, the block accepts the word. Bits 13:12 of the word choose the operating mode. Bits 11:0 carry the unsigned converter code, from 0 to 4095.

The block has three outputs for the analog side:
- the held code;
- a power-down terminating selection with a matching output-enable;
- a one-cycle strobe for every accepted word.

The power-on reset and an asynchronous active-low clear both force the zero-scale code and normal mode at once. After each frame, the link stays locked until it sees a falling serial-clock edge while the frame select is high.

Top module: `sdac_front`

## Requirements
- R1: After reset, dac_code is 0, out_en is 1, term_sel is 000 and upd_stb is 0.
- R2: The first serial bit of a frame is word bit 15. When mode field bits 13:12 are 00 (normal), bits 11:0 of an accepted 16-bit word load dac_code.
- R3: upd_stb pulses high for exactly one clock cycle for each accepted word. It never pulses otherwise.
- R4: A frame that ends with fewer than 16 falling serial-clock edges is discarded. dac_code is unchanged and there is no strobe.
- R5: A frame with more than 16 falling serial-clock edges is discarded in the same way.
- R6: Mode 01 selects the 1 kΩ termination (term_sel bit 0), mode 10 selects 100 kΩ (bit 1) and mode 11 selects high impedance (bit 2). In each of these modes out_en is 0 and dac_code keeps its previous value.
- R7: A normal-mode word (mode 00) after a power-down word restores out_en to 1, clears term_sel and loads the new code.
- R8: Word bits 15:14 have no effect on the result.
- R9: After a frame ends, a new frame is ignored until a falling serial-clock edge has been seen while the frame select is high.
- R10: Driving clr_n low sets dac_code to 0 and out_en to 1 without waiting for a clock edge. After release, the next complete frame loads normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr_n | input | 1 | Asynchronous active-low clear to zero scale |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sync_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial data, MSB first |
| dac_code | output | 12 | Held converter code |
| pd_mode | output | 2 | Current mode: 0 normal, 1 1 kΩ, 2 100 kΩ, 3 high impedance |
| term_sel | output | 3 | One-hot termination select: bit0 1 kΩ, bit1 100 kΩ, bit2 high-Z |
| out_en | output | 1 | Output amplifier enable, high in normal mode |
| upd_stb | output | 1 | One-cycle pulse per accepted word |

## Verification
The bench sends frames of 12 and 17 bits. A design that counted loosely, or kept the last sixteen bits, would load a truncated or shifted code and raise a strobe. It sends a power-down word between two normal words. A design that loaded the data field of a power-down word would show a changed code when the link returns to normal. It also ends a frame without the re-arming clock edge and then sends a full frame; a design that ignored the re-arm rule would accept that frame. Finally, it pulls the clear low between clock edges and checks the code at once, which catches a clear that only acts on a clock edge.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
   localparam int MODE_W = 2;
   typedef enum logic [MODE_W-1:0] {
      PD_NONE = 2'd0,
      PD_1K   = 2'd1,
      PD_100K = 2'd2,
      PD_HIZ  = 2'd3
   } pd_mode_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
   parameter int WIDTH   = 3,
   parameter int STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) stage_q[s] <= RST_VAL;
            else if (s == 0) stage_q[s] <= d;
            else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
   parameter int WORD_W = 16,
   parameter int KEEP_W = 14
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              s_sclk,
   input  logic              s_sync_n,
   input  logic              s_din,
   output logic              frame_vld,
   output logic [KEEP_W-1:0] frame_bits
);
   localparam int CW = $clog2(WORD_W + 2);
   localparam logic [CW-1:0] CNT_FULL = CW'(WORD_W);
   localparam logic [CW-1:0] CNT_OVER = CW'(WORD_W + 1);

   logic          p_sclk, p_sync_n, armed;
   logic [CW-1:0] cnt;
   logic [KEEP_W-1:0] shreg;
   logic          sclk_fall, sync_rise;

   assign sclk_fall = p_sclk & ~s_sclk;
   assign sync_rise = ~p_sync_n & s_sync_n;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         p_sclk   <= 1'b0;
         p_sync_n <= 1'b1;
      end else begin
         p_sclk   <= s_sclk;
         p_sync_n <= s_sync_n;
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         armed     <= 1'b1;
         cnt       <= '0;
         shreg     <= '0;
         frame_vld <= 1'b0;
      end else if (sync_rise) begin
         armed     <= 1'b0;
         cnt       <= '0;
         frame_vld <= armed && (cnt == CNT_FULL);
      end else begin
         frame_vld <= 1'b0;
         if (s_sync_n) begin
            cnt <= '0;
            if (sclk_fall) armed <= 1'b1;
         end else if (sclk_fall && armed) begin
            shreg <= {shreg[KEEP_W-2:0], s_din};
            if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
         end
      end
   end

   assign frame_bits = shreg;
endmodule

// File: rtl/sdac_decode.sv
module sdac_decode
   import sdac_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              frame_vld,
   input  logic [MODE_W-1:0] frame_mode,
   input  logic [DATA_W-1:0] frame_data,
   output logic [DATA_W-1:0] code,
   output pd_mode_e          mode,
   output logic              stb
);
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         code <= '0;
         mode <= PD_NONE;
         stb  <= 1'b0;
      end else begin
         stb <= frame_vld;
         if (frame_vld) begin
            mode <= pd_mode_e'(frame_mode);
            if (pd_mode_e'(frame_mode) == PD_NONE) code <= frame_data;
         end
      end
   end
endmodule

// File: rtl/sdac_front.sv
module sdac_front
   import sdac_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int CTRL_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_n,
   input  logic              sclk,
   input  logic              sync_n,
   input  logic              din,
   output logic [DATA_W-1:0] dac_code,
   output logic [1:0]        pd_mode,
   output logic [2:0]        term_sel,
   output logic              out_en,
   output logic              upd_stb
);
   localparam int WORD_W = DATA_W + CTRL_W;
   localparam int KEEP_W = DATA_W + MODE_W;

   generate
      if (CTRL_W < MODE_W) begin : g_bad_ctrl
         $error("CTRL_W must hold the mode field");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              arst_n;
   logic [2:0]        pins_s;
   logic              frame_vld;
   logic [KEEP_W-1:0] frame_bits;
   pd_mode_e          mode;

   assign arst_n = rst_n & clr_n;

   sdac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
      .clk(clk), .arst_n(arst_n), .d({sclk, sync_n, din}), .q(pins_s)
   );

   sdac_shifter #(.WORD_W(WORD_W), .KEEP_W(KEEP_W)) i_shift (
      .clk(clk), .arst_n(arst_n),
      .s_sclk(pins_s[2]), .s_sync_n(pins_s[1]), .s_din(pins_s[0]),
      .frame_vld(frame_vld), .frame_bits(frame_bits)
   );

   sdac_decode #(.DATA_W(DATA_W)) i_dec (
      .clk(clk), .arst_n(arst_n), .frame_vld(frame_vld),
      .frame_mode(frame_bits[KEEP_W-1:DATA_W]),
      .frame_data(frame_bits[DATA_W-1:0]),
      .code(dac_code), .mode(mode), .stb(upd_stb)
   );

   generate
      for (genvar k = 0; k < 3; k++) begin : g_term
         assign term_sel[k] = (mode == pd_mode_e'(k + 1));
      end
   endgenerate

   assign pd_mode = mode;
   assign out_en  = (mode == PD_NONE);
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
   parameter int DATA_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr_n,
   input logic [DATA_W-1:0] dac_code,
   input logic [2:0]        term_sel,
   input logic              out_en,
   input logic              upd_stb
);
   logic arst_n;
   assign arst_n = rst_n & clr_n;

   AST_TERM_ONEHOT: assert property (@(posedge clk) disable iff (!arst_n)
      $onehot0(term_sel)); // R6

   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!arst_n)
      upd_stb |=> !upd_stb); // R3

   AST_CODE_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!arst_n)
      (dac_code != $past(dac_code)) |-> upd_stb); // R2

   AST_PD_KEEPS_CODE: assert property (@(posedge clk) disable iff (!arst_n)
      (upd_stb && !out_en) |-> $stable(dac_code)); // R6

   always @(posedge clk) begin
      if (!clr_n) begin
         AST_CLR_ZERO: assert (dac_code == '0 && out_en && upd_stb == 1'b0); // R10
      end
   end
endmodule

bind sdac_front sdac_front_chk #(.DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .dac_code(dac_code),
   .term_sel(term_sel), .out_en(out_en), .upd_stb(upd_stb)
);

// File: tb/test_sdac_front.sv
module test_sdac_front;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0, clr_n = 1'b1, sclk = 1'b0, sync_n = 1'b1, din = 1'b0;
   logic [11:0] dac_code;
   logic [1:0]  pd_mode;
   logic [2:0]  term_sel;
   logic        out_en, upd_stb;
   int          total = 0, bad = 0, stb_cnt = 0, stb_base;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   sdac_front i_sdac_front (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sclk(sclk), .sync_n(sync_n),
      .din(din), .dac_code(dac_code), .pd_mode(pd_mode), .term_sel(term_sel),
      .out_en(out_en), .upd_stb(upd_stb)
   );

   always @(posedge clk) if (upd_stb) stb_cnt <= stb_cnt + 1;

   // {word, expected code, expected out_en, expected term_sel}
   localparam logic [31:0] VECS [7] = '{
      32'h0ABCABC8, 32'h0FFFFFF8, 32'h1123FFF1, 32'h2456FFF2,
      32'h3789FFF4, 32'hC0000008, 32'h08008008
   };

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [31:0] bits, input int n, input bit arm);
      sync_n = 1'b0;
      wait_n(4);
      for (int i = n - 1; i >= 0; i--) begin
         sclk = 1'b1; din = bits[i];
         wait_n(4);
         sclk = 1'b0;
         wait_n(4);
      end
      sync_n = 1'b1;
      wait_n(6);
      if (arm) begin
         sclk = 1'b1; wait_n(4);
         sclk = 1'b0; wait_n(4);
      end else begin
         wait_n(8);
      end
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      wait_n(5);
      rst_n = 1'b1;
      wait_n(4);
      check("R1 code", dac_code, 0);
      check("R1 out_en", out_en, 1);
      check("R1 term_sel", term_sel, 0);
      check("R1 upd_stb", upd_stb, 0);

      // R2 R3 R6 R7 R8 through the vector table
      foreach (VECS[v]) begin
         stb_base = stb_cnt;
         send({16'h0, VECS[v][31:16]}, 16, 1'b1);
         check($sformatf("R2/R6/R8 code vec%0d", v), dac_code, VECS[v][15:4]);
         check($sformatf("R7/R6 out_en vec%0d", v), out_en, VECS[v][3]);
         check($sformatf("R6 term vec%0d", v), term_sel, VECS[v][2:0]);
         check($sformatf("R3 strobes vec%0d", v), stb_cnt - stb_base, 1);
      end

      // R4 short frame
      stb_base = stb_cnt;
      send(32'h00000555, 12, 1'b1);
      check("R4 code kept", dac_code, 12'h800);
      check("R4 no strobe", stb_cnt - stb_base, 0);

      // R5 long frame
      send(32'h00000AAA, 17, 1'b1);
      check("R5 code kept", dac_code, 12'h800);
      check("R5 no strobe", stb_cnt - stb_base, 0);

      // R9 no re-arm edge
      send(32'h00000111, 16, 1'b0);
      check("R9 first frame", dac_code, 12'h111);
      stb_base = stb_cnt;
      send(32'h00000222, 16, 1'b1);
      check("R9 frame ignored", dac_code, 12'h111);
      check("R9 no strobe", stb_cnt - stb_base, 0);
      send(32'h00000333, 16, 1'b1);
      check("R9 rearmed", dac_code, 12'h333);

      // R10 asynchronous clear
      send(32'h00001444, 16, 1'b1);
      check("R10 pd before clear", out_en, 0);
      @(negedge clk);
      #1 clr_n = 1'b0;
      #1;
      check("R10 code immediate", dac_code, 0);
      check("R10 out_en immediate", out_en, 1);
      wait_n(3);
      clr_n = 1'b1;
      wait_n(4);
      stb_base = stb_cnt;
      send(32'h00000555, 16, 1'b1);
      check("R10 load after clear", dac_code, 12'h555);
      check("R10 strobe after clear", stb_cnt - stb_base, 1);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule